// File: doc/BRIEF.md
# Optical Transmit Modulator and Pin Router

This block sits between a serial port and an infrared optical transceiver. On the transmit side it takes the UART serial output and can invert it. It can then replace every low stretch of that stream with a carrier burst, and the share of each carrier period spent low is selectable. A final selector decides what drives the optical output pin. The choices are the shaped UART stream, a general-purpose output bit, or one of two pulse-output signals.

On the receive side the digitised comparator result can be inverted on its way to the UART. In a second mode the receive pin is handed over to general-purpose input use. In that mode the UART sees an idle high level and the inversion setting is ignored.

The carrier is produced by a free-running counter that advances once per carrier-enable tick. Every output is registered, so the pin and the receive outputs change only on a clock edge, one cycle after their inputs.

Top module: `optx_shaper`

## Requirements
- R1: While `rst_n` is low, `opt_pin` is 1, `uart_rxd` is 1 and `gpio_rx` is 0. The internal carrier counter and the latched duty code reset to 0.
- R2: With `mod_en` = 0 and `pin_sel` = 00, `opt_pin` equals `uart_txd` XOR `tx_inv`. The inversion is applied before any modulation.
- R3: With `mod_en` = 1 and `pin_sel` = 00, `opt_pin` is 1 whenever `uart_txd` XOR `tx_inv` is 1. Only when that value is 0 does the carrier drive the pin.
- R4: The carrier period is 16 ticks. The carrier is low for the first L tick positions of the period (counter values 0 to L-1) and high for the rest. L is 8, 4, 2 or 1 for duty codes 00, 01, 10 and 11.
- R5: A new `duty_sel` value is latched only when the counter wraps from 15 to 0 on a tick. Until then, the carrier keeps the duty code it already holds.
- R6: `pin_sel` selects the pin source: 00 is the shaped UART stream, 01 is `gpo_bit`, 10 is `pulse_a` and 11 is `pulse_b`.
- R7: With `rx_gpio_mode` = 0, `uart_rxd` equals `rx_comp` XOR `rx_inv`, and `gpio_rx` is 0.
- R8: With `rx_gpio_mode` = 1, `gpio_rx` equals `rx_comp` regardless of `rx_inv`, and `uart_rxd` is held at 1.
- R9: Each output reflects its inputs one clock cycle later. Between clock edges, no output changes.
- R10: The carrier counter advances only on cycles where `carrier_tick` is 1. It is never restarted by data edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| carrier_tick | input | 1 | Carrier counter advance enable |
| duty_sel | input | 2 | Carrier low-fraction code |
| tx_inv | input | 1 | Invert transmit data |
| mod_en | input | 1 | Enable carrier on low data |
| pin_sel | input | 2 | Optical pin source select |
| uart_txd | input | 1 | UART serial transmit data |
| gpo_bit | input | 1 | General-purpose output bit |
| pulse_a | input | 1 | First pulse-output signal |
| pulse_b | input | 1 | Second pulse-output signal |
| rx_comp | input | 1 | Digitised receive comparator result |
| rx_inv | input | 1 | Invert receive data toward the UART |
| rx_gpio_mode | input | 1 | Receive pin used as general-purpose input |
| opt_pin | output | 1 | Optical transmit pin drive |
| uart_rxd | output | 1 | Receive data to the UART |
| gpio_rx | output | 1 | Receive pin level for general-purpose input |

## Verification
The critical overlap is a carrier-period wrap that falls in the same cycle as a duty-code change and a low data bit. In that cycle the counter wrap, the duty latch and the modulation decision all act together. The bench provokes this with directed sequences: it changes `duty_sel` in the middle of a period, and again right at the wrap, while `mod_en` is set and the data is low. It also applies random ticks, data and codes. A bench model of the counter decides, for every cycle, whether the old or the new low length applies, and each registered pin value is compared against that model.

// File: rtl/optx_pkg.sv
package optx_pkg;
   typedef enum logic [1:0] {
      SRC_UART    = 2'b00,
      SRC_GPO     = 2'b01,
      SRC_PULSE_A = 2'b10,
      SRC_PULSE_B = 2'b11
   } optx_src_e;
endpackage

// File: rtl/optx_carrier_gen.sv
module optx_carrier_gen #(
   parameter int CNT_W     = 4,
   parameter int DUTY_W    = 2,
   parameter bit LOW_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [DUTY_W-1:0] duty_sel,
   output logic              carrier
);
   localparam int           PERIOD  = 2 ** CNT_W;
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(PERIOD - 1);

   initial begin
      if (CNT_W < 2) $error("CNT_W too small");
      if (CNT_W - 1 < (2 ** DUTY_W) - 1) $error("DUTY_W too wide for CNT_W");
   end

   logic [CNT_W-1:0]  cnt;
   logic [DUTY_W-1:0] duty_q;
   logic [CNT_W:0]    low_len;
   logic              wrap;

   assign wrap = tick && (cnt == CNT_MAX);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt    <= '0;
         duty_q <= '0;
      end else if (tick) begin
         if (wrap) begin
            cnt    <= '0;
            duty_q <= duty_sel;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   always_comb begin
      low_len = (CNT_W+1)'(1) << (CNT_W - 1 - int'(duty_q));
   end

   generate
      if (LOW_FIRST) begin : g_low_first
         assign carrier = ({1'b0, cnt} < low_len) ? 1'b0 : 1'b1;
      end else begin : g_low_last
         assign carrier = ({1'b0, cnt} >= ((CNT_W+1)'(PERIOD) - low_len)) ? 1'b0 : 1'b1;
      end
   endgenerate

   // R10
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(cnt));

   // R5
   duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap |=> $stable(duty_q));
endmodule

// File: rtl/optx_tx_path.sv
module optx_tx_path
   import optx_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       carrier,
   input  logic       uart_txd,
   input  logic       tx_inv,
   input  logic       mod_en,
   input  logic [1:0] pin_sel,
   input  logic       gpo_bit,
   input  logic       pulse_a,
   input  logic       pulse_b,
   output logic       pin
);
   logic data_pol;
   logic shaped;
   logic pin_d;

   assign data_pol = uart_txd ^ tx_inv;
   assign shaped   = mod_en ? (data_pol | carrier) : data_pol;

   always_comb begin
      unique case (optx_src_e'(pin_sel))
         SRC_UART:    pin_d = shaped;
         SRC_GPO:     pin_d = gpo_bit;
         SRC_PULSE_A: pin_d = pulse_a;
         SRC_PULSE_B: pin_d = pulse_b;
         default:     pin_d = shaped;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) pin <= 1'b1;
      else        pin <= pin_d;
   end

   // R3
   mark_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_sel == 2'b00 && (uart_txd ^ tx_inv)) |=> pin);

   // R2
   plain_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_sel == 2'b00 && !mod_en) |=> (pin == $past(uart_txd ^ tx_inv)));

   // R6
   sel_gpo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_sel == 2'b01) |=> (pin == $past(gpo_bit)));
endmodule

// File: rtl/optx_rx_path.sv
module optx_rx_path (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_comp,
   input  logic rx_inv,
   input  logic rx_gpio_mode,
   output logic uart_rxd,
   output logic gpio_rx
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         uart_rxd <= 1'b1;
         gpio_rx  <= 1'b0;
      end else if (rx_gpio_mode) begin
         uart_rxd <= 1'b1;
         gpio_rx  <= rx_comp;
      end else begin
         uart_rxd <= rx_comp ^ rx_inv;
         gpio_rx  <= 1'b0;
      end
   end

   // R8
   rx_gpio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_gpio_mode |=> (uart_rxd && gpio_rx == $past(rx_comp)));

   // R7
   rx_uart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_gpio_mode |=> (!gpio_rx && uart_rxd == $past(rx_comp ^ rx_inv)));
endmodule

// File: rtl/optx_shaper.sv
module optx_shaper #(
   parameter int CNT_W     = 4,
   parameter bit LOW_FIRST = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       carrier_tick,
   input  logic [1:0] duty_sel,
   input  logic       tx_inv,
   input  logic       mod_en,
   input  logic [1:0] pin_sel,
   input  logic       uart_txd,
   input  logic       gpo_bit,
   input  logic       pulse_a,
   input  logic       pulse_b,
   input  logic       rx_comp,
   input  logic       rx_inv,
   input  logic       rx_gpio_mode,
   output logic       opt_pin,
   output logic       uart_rxd,
   output logic       gpio_rx
);
   localparam int DUTY_W = 2;

   logic carrier;

   optx_carrier_gen #(
      .CNT_W    (CNT_W),
      .DUTY_W   (DUTY_W),
      .LOW_FIRST(LOW_FIRST)
   ) u_carrier (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (carrier_tick),
      .duty_sel(duty_sel),
      .carrier (carrier)
   );

   optx_tx_path u_tx (
      .clk     (clk),
      .rst_n   (rst_n),
      .carrier (carrier),
      .uart_txd(uart_txd),
      .tx_inv  (tx_inv),
      .mod_en  (mod_en),
      .pin_sel (pin_sel),
      .gpo_bit (gpo_bit),
      .pulse_a (pulse_a),
      .pulse_b (pulse_b),
      .pin     (opt_pin)
   );

   optx_rx_path u_rx (
      .clk         (clk),
      .rst_n       (rst_n),
      .rx_comp     (rx_comp),
      .rx_inv      (rx_inv),
      .rx_gpio_mode(rx_gpio_mode),
      .uart_rxd    (uart_rxd),
      .gpio_rx     (gpio_rx)
   );

   // R1
   reset_out_chk: assert property (@(posedge clk)
      !rst_n |=> (opt_pin && uart_rxd && !gpio_rx));
endmodule

// File: tb/optx_shaper_test.sv
module optx_shaper_test;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       carrier_tick = 1'b0;
   logic [1:0] duty_sel = 2'b00;
   logic       tx_inv = 1'b0;
   logic       mod_en = 1'b0;
   logic [1:0] pin_sel = 2'b00;
   logic       uart_txd = 1'b1;
   logic       gpo_bit = 1'b0;
   logic       pulse_a = 1'b0;
   logic       pulse_b = 1'b0;
   logic       rx_comp = 1'b0;
   logic       rx_inv = 1'b0;
   logic       rx_gpio_mode = 1'b0;
   logic       opt_pin;
   logic       uart_rxd;
   logic       gpio_rx;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   int         m_cnt = 0;
   logic [1:0] m_duty = 2'b00;

   always #(CLK_PERIOD / 2) clk = ~clk;

   optx_shaper uut (
      .clk(clk), .rst_n(rst_n), .carrier_tick(carrier_tick), .duty_sel(duty_sel),
      .tx_inv(tx_inv), .mod_en(mod_en), .pin_sel(pin_sel), .uart_txd(uart_txd),
      .gpo_bit(gpo_bit), .pulse_a(pulse_a), .pulse_b(pulse_b), .rx_comp(rx_comp),
      .rx_inv(rx_inv), .rx_gpio_mode(rx_gpio_mode), .opt_pin(opt_pin),
      .uart_rxd(uart_rxd), .gpio_rx(gpio_rx)
   );

   function automatic logic f_carrier(int cnt, logic [1:0] duty);
      int low_len = 8 >> duty;
      return (cnt < low_len) ? 1'b0 : 1'b1;
   endfunction

   function automatic logic f_pin(logic [1:0] sel, logic car);
      logic d = uart_txd ^ tx_inv;
      logic u = mod_en ? (d | car) : d;
      case (sel)
         2'b00:   return u;
         2'b01:   return gpo_bit;
         2'b10:   return pulse_a;
         default: return pulse_b;
      endcase
   endfunction

   task automatic check(string tag, logic act, logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic step(string tag);
      logic e_pin, e_urx, e_grx;
      e_pin = f_pin(pin_sel, f_carrier(m_cnt, m_duty));
      e_urx = rx_gpio_mode ? 1'b1 : (rx_comp ^ rx_inv);
      e_grx = rx_gpio_mode ? rx_comp : 1'b0;
      @(posedge clk);
      if (carrier_tick) begin
         if (m_cnt == 15) begin
            m_cnt  = 0;
            m_duty = duty_sel;
         end else begin
            m_cnt++;
         end
      end
      #1;
      check({tag, " opt_pin"}, opt_pin, e_pin);
      check("R7/R8 uart_rxd", uart_rxd, e_urx);
      check("R7/R8 gpio_rx", gpio_rx, e_grx);
      @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      // R1: outputs in reset
      check("R1 opt_pin", opt_pin, 1'b1);
      check("R1 uart_rxd", uart_rxd, 1'b1);
      check("R1 gpio_rx", gpio_rx, 1'b0);
      rst_n = 1'b1;

      // R9: outputs do not move between edges
      pin_sel = 2'b01;
      gpo_bit = 1'b0;
      step("R6");
      gpo_bit = 1'b1;
      #1;
      check("R9 opt_pin before edge", opt_pin, 1'b0);
      step("R9");

      // R4: each duty code over full periods, low data, steady ticks
      pin_sel = 2'b00;
      mod_en = 1'b1;
      uart_txd = 1'b0;
      carrier_tick = 1'b1;
      for (int d = 0; d < 4; d++) begin
         duty_sel = 2'(d);
         repeat (32) step("R4");
      end

      // R5: change duty in mid-period, old code holds until wrap
      duty_sel = 2'b00;
      while (!(m_cnt == 0 && m_duty == 2'b00)) step("R5");
      repeat (4) step("R5");
      duty_sel = 2'b11;
      repeat (4) step("R5 old duty kept");
      repeat (20) step("R5 new duty");
      // R5: change right at the wrap cycle
      while (m_cnt != 15) step("R5");
      duty_sel = 2'b01;
      repeat (18) step("R5 wrap edge");

      // R2/R3: inversion before modulation
      tx_inv = 1'b1;
      uart_txd = 1'b1;
      repeat (16) step("R2 inverted mark modulated");
      uart_txd = 1'b0;
      repeat (4) step("R3 inverted space high");
      tx_inv = 1'b0;

      // R10: no ticks, counter frozen in low phase
      duty_sel = 2'b00;
      while (m_cnt != 2) step("R10");
      carrier_tick = 1'b0;
      repeat (10) step("R10 frozen");
      carrier_tick = 1'b1;

      // R8: inversion ignored in gpio mode
      rx_gpio_mode = 1'b1;
      rx_inv = 1'b1;
      rx_comp = 1'b1;
      step("R8");
      rx_comp = 1'b0;
      step("R8");

      // random mix
      for (int i = 0; i < 4000; i++) begin
         carrier_tick = 1'($urandom);
         if ($urandom_range(0, 15) == 0) duty_sel = 2'($urandom);
         if ($urandom_range(0, 31) == 0) pin_sel = 2'($urandom);
         if ($urandom_range(0, 31) == 0) tx_inv = 1'($urandom);
         if ($urandom_range(0, 31) == 0) mod_en = 1'($urandom);
         if ($urandom_range(0, 7) == 0) uart_txd = 1'($urandom);
         gpo_bit = 1'($urandom);
         pulse_a = 1'($urandom);
         pulse_b = 1'($urandom);
         rx_comp = 1'($urandom);
         if ($urandom_range(0, 15) == 0) rx_inv = 1'($urandom);
         if ($urandom_range(0, 15) == 0) rx_gpio_mode = 1'($urandom);
         step(pin_sel != 2'b00 ? "R6" : (mod_en ? "R3/R4" : "R2"));
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule